// File: doc/BRIEF.md
# Block Storage Controller Register Target

This block is the register side of a DMA-driven block-storage controller. It receives single-word reads and writes from a simple request/response bus and holds the parameters of a transfer: a 64-bit memory buffer address split into two words, a block count and a starting block index. It also holds an interrupt enable, and it supplies two constant words that give the device capacity in blocks and the block size in bytes. When software writes a read or write operation code, the block sends a one-cycle start pulse to a separate DMA engine. From that point it shows a busy status until the engine reports completion.

The engine signals the end of a transfer with a done pulse and a fail flag. The block then moves to one of four completion codes. While a completion code is present and the interrupt is enabled, a level interrupt is raised. A read of the status register returns the completion code and then returns the block to idle, which acknowledges the interrupt. While a transfer is in flight, the transfer parameters are protected: writes to them are accepted on the bus but have no effect.

Top module: `bdc_target`

## Requirements
- R1: After reset the status code is 0 (idle), the interrupt enable reads 1, the buffer, count and block index words read 0, and irq, eng_start and rsp_valid are low.
- R2: Registers sit at byte offsets 0x00 buffer low, 0x04 count, 0x08 block index, 0x0C operation (write-only), 0x10 status (read-only), 0x14 interrupt enable, 0x18 device size (read-only, the DEV_BLOCKS parameter), 0x1C block size (read-only, the BLK_BYTES parameter) and 0x20 buffer high. A write to a writable parameter word while idle is read back unchanged.
- R3: While idle, writing 1 (read) or 2 (write) to the operation register raises eng_start for exactly one cycle, sets eng_read to 1 for read and 0 for write, and changes the status to 1 (busy). Any other value leaves the status idle and gives no pulse.
- R4: While busy, an eng_done pulse sets the status to 2 (read success), 3 (write success), 4 (read error) or 5 (write error), chosen by the direction and by eng_fail. eng_done has no effect outside busy.
- R5: irq is high exactly when the status is 2 to 5 and the interrupt enable is set. Writing any non-zero value sets the enable, writing 0 clears it, the enable reads back as 1 or 0, and it can be written in any state.
- R6: A status read in a completion state returns that code, and the status is 0 from the next cycle on, so irq drops. A status read in idle or busy changes nothing.
- R7: While the status is not idle, writes to buffer low, buffer high, count, block index and operation get a normal response but change nothing.
- R8: An access to an offset that is not word-aligned or lies beyond 0x20, a read of the operation register, or a write to the status, device size or block size register returns rsp_error = 1 with zero data and changes no state.
- R9: Each cycle with req_valid high produces exactly one response, with rsp_valid high in the next cycle. The response echoes the request's source, transaction and packet identifiers. Write responses carry zero data.
- R10: eng_buf_addr is {buffer high, buffer low}, and eng_count and eng_lba equal the count and block index registers at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the register window |
| req_wdata | input | 32 | Write data |
| req_srcid | input | SRC_W | Requester source identifier |
| req_trdid | input | TRD_W | Requester transaction identifier |
| req_pktid | input | PKT_W | Requester packet identifier |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_error | output | 1 | Access rejected |
| rsp_srcid | output | SRC_W | Echoed source identifier |
| rsp_trdid | output | TRD_W | Echoed transaction identifier |
| rsp_pktid | output | PKT_W | Echoed packet identifier |
| eng_start | output | 1 | One-cycle transfer start pulse |
| eng_read | output | 1 | Transfer direction, 1 = device to memory |
| eng_buf_addr | output | 64 | Memory buffer address |
| eng_count | output | 32 | Number of blocks |
| eng_lba | output | 32 | First block index |
| eng_done | input | 1 | Engine finished the transfer (pulse) |
| eng_fail | input | 1 | Qualifies eng_done as a failure |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets several corner cases. It reads status in each of the four completion states and then reads it again; a design that never clears the state would keep irq stuck high, and one that clears it before the response would return 0. It writes parameters and the operation register while busy and while in a completion state; a design that gates only on busy would let a second start slip through before acknowledgement. It applies a done pulse while idle, no-op and unknown operation codes, and every error class (misaligned, past the window, read-only written, write-only read); a faulty design would change state or return a normal response. It also toggles the enable with arbitrary non-zero values while a completion is pending, which catches an enable that tests only bit 0.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

    localparam int WORD_W = 32;
    localparam int REG_IDX_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_BUSY   = 3'd1,
        ST_RD_OK  = 3'd2,
        ST_WR_OK  = 3'd3,
        ST_RD_ERR = 3'd4,
        ST_WR_ERR = 3'd5
    } bdc_state_e;

    typedef enum logic [REG_IDX_W-1:0] {
        RG_BUF_LO  = 4'd0,
        RG_COUNT   = 4'd1,
        RG_LBA     = 4'd2,
        RG_OP      = 4'd3,
        RG_STATUS  = 4'd4,
        RG_IRQEN   = 4'd5,
        RG_DEVSIZE = 4'd6,
        RG_BLKSIZE = 4'd7,
        RG_BUF_HI  = 4'd8,
        RG_NONE    = 4'd15
    } bdc_reg_e;

    localparam logic [WORD_W-1:0] OPC_READ  = 32'd1;
    localparam logic [WORD_W-1:0] OPC_WRITE = 32'd2;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              err;
        bdc_reg_e          sel;
        logic [WORD_W-1:0] wdata;
    } bdc_acc_t;

    function automatic logic st_complete(input bdc_state_e s);
        return (s == ST_RD_OK) || (s == ST_WR_OK) ||
               (s == ST_RD_ERR) || (s == ST_WR_ERR);
    endfunction

    function automatic logic reg_readable(input bdc_reg_e r);
        return (r != RG_OP) && (r != RG_NONE);
    endfunction

    function automatic logic reg_writable(input bdc_reg_e r);
        case (r)
            RG_BUF_LO, RG_BUF_HI, RG_COUNT, RG_LBA, RG_OP, RG_IRQEN: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic reg_guarded(input bdc_reg_e r);
        case (r)
            RG_BUF_LO, RG_BUF_HI, RG_COUNT, RG_LBA, RG_OP: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bdc_decode.sv
module bdc_decode
    import bdc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output bdc_acc_t          acc
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int LAST_IDX = 8;

    logic [IDX_W-1:0] word_idx;
    logic             aligned;
    bdc_reg_e         sel;

    assign word_idx = req_addr[ADDR_W-1:2];
    assign aligned  = (req_addr[1:0] == 2'b00);

    always_comb begin
        if (aligned && (word_idx <= IDX_W'(LAST_IDX)))
            sel = bdc_reg_e'(word_idx[REG_IDX_W-1:0]);
        else
            sel = RG_NONE;
    end

    always_comb begin
        acc.valid = req_valid;
        acc.write = req_write;
        acc.sel   = sel;
        acc.wdata = req_wdata;
        acc.err   = req_valid &&
                    (req_write ? !reg_writable(sel) : !reg_readable(sel));
    end
endmodule

// File: rtl/bdc_status.sv
module bdc_status
    import bdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       dir_read,
    input  logic       done,
    input  logic       fail,
    input  logic       ack,
    output bdc_state_e state_q
);
    bdc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_BUSY;
            ST_BUSY: begin
                if (done) begin
                    if (fail) state_d = dir_read ? ST_RD_ERR : ST_WR_ERR;
                    else      state_d = dir_read ? ST_RD_OK  : ST_WR_OK;
                end
            end
            ST_RD_OK, ST_WR_OK, ST_RD_ERR, ST_WR_ERR:
                if (ack) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/bdc_params.sv
module bdc_params
    import bdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bdc_acc_t          acc,
    input  logic              idle,
    output logic [WORD_W-1:0] buf_lo_q,
    output logic [WORD_W-1:0] buf_hi_q,
    output logic [WORD_W-1:0] count_q,
    output logic [WORD_W-1:0] lba_q,
    output logic              ien_q
);
    logic wr_ok;
    logic guarded_ok;

    assign wr_ok      = acc.valid && acc.write && !acc.err;
    assign guarded_ok = wr_ok && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_lo_q <= '0;
            buf_hi_q <= '0;
            count_q  <= '0;
            lba_q    <= '0;
            ien_q    <= 1'b1;
        end else begin
            if (guarded_ok && acc.sel == RG_BUF_LO) buf_lo_q <= acc.wdata;
            if (guarded_ok && acc.sel == RG_BUF_HI) buf_hi_q <= acc.wdata;
            if (guarded_ok && acc.sel == RG_COUNT)  count_q  <= acc.wdata;
            if (guarded_ok && acc.sel == RG_LBA)    lba_q    <= acc.wdata;
            if (wr_ok && acc.sel == RG_IRQEN)       ien_q    <= |acc.wdata;
        end
    end
endmodule

// File: rtl/bdc_target.sv
module bdc_target
    import bdc_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          SRC_W      = 8,
    parameter int          TRD_W      = 4,
    parameter int          PKT_W      = 4,
    parameter logic [31:0] DEV_BLOCKS = 32'd4096,
    parameter logic [31:0] BLK_BYTES  = 32'd512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [SRC_W-1:0]  req_srcid,
    input  logic [TRD_W-1:0]  req_trdid,
    input  logic [PKT_W-1:0]  req_pktid,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_error,
    output logic [SRC_W-1:0]  rsp_srcid,
    output logic [TRD_W-1:0]  rsp_trdid,
    output logic [PKT_W-1:0]  rsp_pktid,
    output logic              eng_start,
    output logic              eng_read,
    output logic [63:0]       eng_buf_addr,
    output logic [31:0]       eng_count,
    output logic [31:0]       eng_lba,
    input  logic              eng_done,
    input  logic              eng_fail,
    output logic              irq
);
    bdc_acc_t          acc;
    bdc_state_e        st_q;
    logic [WORD_W-1:0] buf_lo_q, buf_hi_q, count_q, lba_q;
    logic              ien_q;
    logic              idle;
    logic              legal_rd, legal_wr;
    logic              start_go, status_ack;
    logic              dir_q;
    logic [WORD_W-1:0] rd_mux;

    bdc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .acc       (acc)
    );

    assign idle     = (st_q == ST_IDLE);
    assign legal_rd = acc.valid && !acc.write && !acc.err;
    assign legal_wr = acc.valid &&  acc.write && !acc.err;

    assign start_go = legal_wr && idle && (acc.sel == RG_OP) &&
                      ((acc.wdata == OPC_READ) || (acc.wdata == OPC_WRITE));
    assign status_ack = legal_rd && (acc.sel == RG_STATUS);

    bdc_params u_par (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .idle     (idle),
        .buf_lo_q (buf_lo_q),
        .buf_hi_q (buf_hi_q),
        .count_q  (count_q),
        .lba_q    (lba_q),
        .ien_q    (ien_q)
    );

    bdc_status u_st (
        .clk      (clk),
        .rst      (rst),
        .start    (start_go),
        .dir_read (dir_q),
        .done     (eng_done),
        .fail     (eng_fail),
        .ack      (status_ack),
        .state_q  (st_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q     <= 1'b0;
            eng_start <= 1'b0;
        end else begin
            eng_start <= start_go;
            if (start_go) dir_q <= (acc.wdata == OPC_READ);
        end
    end

    always_comb begin
        unique case (acc.sel)
            RG_BUF_LO:  rd_mux = buf_lo_q;
            RG_BUF_HI:  rd_mux = buf_hi_q;
            RG_COUNT:   rd_mux = count_q;
            RG_LBA:     rd_mux = lba_q;
            RG_STATUS:  rd_mux = WORD_W'(st_q);
            RG_IRQEN:   rd_mux = WORD_W'(ien_q);
            RG_DEVSIZE: rd_mux = DEV_BLOCKS;
            RG_BLKSIZE: rd_mux = BLK_BYTES;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_error <= 1'b0;
            rsp_srcid <= '0;
            rsp_trdid <= '0;
            rsp_pktid <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_rdata <= legal_rd ? rd_mux : '0;
                rsp_error <= acc.err;
                rsp_srcid <= req_srcid;
                rsp_trdid <= req_trdid;
                rsp_pktid <= req_pktid;
            end
        end
    end

    assign eng_read     = dir_q;
    assign eng_buf_addr = {buf_hi_q, buf_lo_q};
    assign eng_count    = count_q;
    assign eng_lba      = lba_q;
    assign irq          = ien_q && st_complete(st_q);

endmodule

// File: rtl/bdc_target_chk.sv
module bdc_target_chk
    import bdc_pkg::*;
#(
    parameter int SRC_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [SRC_W-1:0] req_srcid,
    input logic             rsp_valid,
    input logic [SRC_W-1:0] rsp_srcid,
    input logic             eng_start,
    input logic [31:0]      eng_count,
    input logic             irq,
    input bdc_state_e       st,
    input logic             ien
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);  // R9
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);  // R9
    AST_SRCID_ECHO: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_srcid == $past(req_srcid)));  // R9
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);  // R3
    AST_START_ENTERS_BUSY: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> (st == ST_BUSY));  // R3
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq |-> ien);  // R5
    AST_IRQ_NEEDS_COMPLETION: assert property (@(posedge clk) disable iff (rst)
        irq |-> (st != ST_IDLE && st != ST_BUSY));  // R5
    AST_PARAMS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> $stable(eng_count));  // R7
endmodule

bind bdc_target bdc_target_chk #(.SRC_W(SRC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_srcid (req_srcid),
    .rsp_valid (rsp_valid),
    .rsp_srcid (rsp_srcid),
    .eng_start (eng_start),
    .eng_count (eng_count),
    .irq       (irq),
    .st        (st_q),
    .ien       (ien_q)
);

// File: tb/bdc_target_tb.sv
module bdc_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] DEVB = 32'd4096;
    localparam logic [31:0] BLKB = 32'd512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  req_srcid = '0;
    logic [3:0]  req_trdid = '0, req_pktid = '0;
    logic        rsp_valid, rsp_error, eng_start, eng_read, irq;
    logic [31:0] rsp_rdata, eng_count, eng_lba;
    logic [7:0]  rsp_srcid;
    logic [3:0]  rsp_trdid, rsp_pktid;
    logic [63:0] eng_buf_addr;
    logic        eng_done = 1'b0, eng_fail = 1'b0;

    int n_vec = 0, n_bad = 0;
    bit run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bdc_target u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_srcid(req_srcid),
        .req_trdid(req_trdid), .req_pktid(req_pktid), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_error(rsp_error), .rsp_srcid(rsp_srcid),
        .rsp_trdid(rsp_trdid), .rsp_pktid(rsp_pktid), .eng_start(eng_start),
        .eng_read(eng_read), .eng_buf_addr(eng_buf_addr), .eng_count(eng_count),
        .eng_lba(eng_lba), .eng_done(eng_done), .eng_fail(eng_fail), .irq(irq)
    );

    // behavioural reference model
    int          m_st, m_ien;
    logic [31:0] m_lo, m_hi, m_cnt, m_lba;
    bit          m_rd;
    bit          e_rv, e_err, e_start;
    logic [31:0] e_rdata;
    logic [7:0]  e_src;
    logic [3:0]  e_trd, e_pkt;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_ien = 1; m_lo = 0; m_hi = 0; m_cnt = 0; m_lba = 0;
            m_rd = 0; e_rv = 0; e_start = 0;
        end else begin
            int st0, idx;
            bit known;
            st0 = m_st;
            e_rv = req_valid;
            e_start = 0;
            if (req_valid) begin
                idx   = int'(req_addr) / 4;
                known = (req_addr % 4 == 0) && (idx <= 8);
                e_src = req_srcid; e_trd = req_trdid; e_pkt = req_pktid;
                e_err = !known || (req_write ? (idx == 4 || idx == 6 || idx == 7)
                                             : (idx == 3));
                e_rdata = 0;
                if (!e_err && !req_write) begin
                    case (idx)
                        0: e_rdata = m_lo;
                        1: e_rdata = m_cnt;
                        2: e_rdata = m_lba;
                        4: e_rdata = st0;
                        5: e_rdata = m_ien;
                        6: e_rdata = DEVB;
                        7: e_rdata = BLKB;
                        8: e_rdata = m_hi;
                        default: e_rdata = 0;
                    endcase
                    if (idx == 4 && st0 >= 2) m_st = 0;
                end
                if (!e_err && req_write) begin
                    if (idx == 5) m_ien = (req_wdata != 0) ? 1 : 0;
                    if (st0 == 0) begin
                        case (idx)
                            0: m_lo = req_wdata;
                            1: m_cnt = req_wdata;
                            2: m_lba = req_wdata;
                            8: m_hi = req_wdata;
                            3: if (req_wdata == 1 || req_wdata == 2) begin
                                   e_start = 1; m_rd = (req_wdata == 1); m_st = 1;
                               end
                            default: ;
                        endcase
                    end
                end
            end
            if (eng_done && st0 == 1)
                m_st = m_rd ? (eng_fail ? 4 : 2) : (eng_fail ? 5 : 3);
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (run) begin
            chk("R9 rsp_valid", 64'(rsp_valid), 64'(e_rv));
            if (e_rv) begin
                chk("R9 ids", 64'({rsp_srcid, rsp_trdid, rsp_pktid}),
                    64'({e_src, e_trd, e_pkt}));
                chk("R8 rsp_error", 64'(rsp_error), 64'(e_err));
                chk("R2 rsp_rdata", 64'(rsp_rdata), 64'(e_rdata));
            end
            chk("R3 eng_start", 64'(eng_start), 64'(e_start));
            chk("R3 eng_read", 64'(eng_read), 64'(m_rd));
            chk("R5 irq", 64'(irq), 64'((m_st >= 2) && (m_ien != 0)));
            chk("R10 eng_buf_addr", eng_buf_addr, {m_hi, m_lo});
            chk("R10 eng_count", 64'(eng_count), 64'(m_cnt));
            chk("R10 eng_lba", 64'(eng_lba), 64'(m_lba));
        end
    end

    logic [31:0] rd_d;
    logic        rd_e;
    logic [7:0]  tag_id = 8'h10;

    task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        tag_id = tag_id + 8'd7;
        req_srcid = tag_id; req_trdid = tag_id[3:0] ^ 4'h5; req_pktid = tag_id[7:4];
        @(negedge clk);
        req_valid = 0;
        rd_d = rsp_rdata; rd_e = rsp_error;
    endtask

    task automatic done_pulse(input bit f);
        @(negedge clk);
        eng_done = 1; eng_fail = f;
        @(negedge clk);
        eng_done = 0; eng_fail = 0;
    endtask

    task automatic run_op(input logic [31:0] op, input bit f, input logic [31:0] code);
        access(1, 8'h0C, op);
        access(0, 8'h10, 0); chk("R3 busy after start", 64'(rd_d), 64'd1);
        done_pulse(f);
        access(0, 8'h10, 0); chk("R4 completion code", 64'(rd_d), 64'(code));
        access(0, 8'h10, 0); chk("R6 idle after ack", 64'(rd_d), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        run = 1;
        chk("R1 irq reset", 64'(irq), 64'd0);
        chk("R1 start reset", 64'(eng_start), 64'd0);
        chk("R1 rsp reset", 64'(rsp_valid), 64'd0);
        access(0, 8'h10, 0); chk("R1 status idle", 64'(rd_d), 64'd0);
        access(0, 8'h14, 0); chk("R1 irq enable", 64'(rd_d), 64'd1);
        access(0, 8'h04, 0); chk("R1 count zero", 64'(rd_d), 64'd0);

        access(1, 8'h00, 32'hDEAD_0040);
        access(1, 8'h20, 32'h0000_0003);
        access(1, 8'h04, 32'd8);
        access(1, 8'h08, 32'd1234);
        access(0, 8'h00, 0); chk("R2 buf lo", 64'(rd_d), 64'hDEAD_0040);
        access(0, 8'h20, 0); chk("R2 buf hi", 64'(rd_d), 64'h3);
        access(0, 8'h08, 0); chk("R2 lba", 64'(rd_d), 64'd1234);
        access(0, 8'h18, 0); chk("R2 dev size", 64'(rd_d), 64'(DEVB));
        access(0, 8'h1C, 0); chk("R2 blk size", 64'(rd_d), 64'(BLKB));
        chk("R10 buf addr", eng_buf_addr, 64'h3_DEAD_0040);

        access(1, 8'h0C, 32'd0);
        access(0, 8'h10, 0); chk("R3 noop stays idle", 64'(rd_d), 64'd0);
        access(1, 8'h0C, 32'd7);
        access(0, 8'h10, 0); chk("R3 unknown op idle", 64'(rd_d), 64'd0);
        done_pulse(0);
        access(0, 8'h10, 0); chk("R4 done ignored idle", 64'(rd_d), 64'd0);

        // read transfer, writes while busy dropped
        access(1, 8'h0C, 32'd1);
        access(1, 8'h04, 32'd99);
        access(1, 8'h20, 32'h55);
        access(1, 8'h0C, 32'd2);
        access(0, 8'h04, 0); chk("R7 count kept", 64'(rd_d), 64'd8);
        chk("R7 dir kept", 64'(eng_read), 64'd1);
        done_pulse(0);
        chk("R5 irq on completion", 64'(irq), 64'd1);
        access(1, 8'h00, 32'h1);
        access(1, 8'h0C, 32'd2);
        chk("R7 no start while done", 64'(eng_start), 64'd0);
        access(1, 8'h14, 32'h0);
        chk("R5 irq masked", 64'(irq), 64'd0);
        access(1, 8'h14, 32'h100);
        chk("R5 nonzero enables", 64'(irq), 64'd1);
        access(0, 8'h10, 0); chk("R6 returns code", 64'(rd_d), 64'd2);
        chk("R6 irq dropped", 64'(irq), 64'd0);
        access(0, 8'h00, 0); chk("R7 lo kept", 64'(rd_d), 64'hDEAD_0040);

        run_op(32'd2, 0, 32'd3);
        run_op(32'd1, 1, 32'd4);
        run_op(32'd2, 1, 32'd5);

        access(0, 8'h24, 0); chk("R8 past window", 64'(rd_e), 64'd1);
        access(0, 8'h02, 0); chk("R8 misaligned", 64'(rd_e), 64'd1);
        access(0, 8'h0C, 0); chk("R8 read op", 64'(rd_e), 64'd1);
        access(1, 8'h18, 32'h7); chk("R8 write size", 64'(rd_e), 64'd1);
        access(1, 8'h10, 32'h2); chk("R8 write status", 64'(rd_e), 64'd1);
        access(1, 8'h05, 32'h9); chk("R8 misaligned write", 64'(rd_e), 64'd1);
        access(1, 8'hF0, 32'h1); chk("R8 far write", 64'(rd_e), 64'd1);
        access(0, 8'h10, 0); chk("R8 status untouched", 64'(rd_d), 64'd0);

        // back-to-back requests
        @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            req_valid = 1; req_write = 0; req_addr = 8'(i * 4);
            req_srcid = 8'(i); req_trdid = 4'(i); req_pktid = 4'(15 - i);
            @(negedge clk);
        end
        req_valid = 0;
        repeat (3) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule